// File: doc/BRIEF.md
# Floating-point narrowing format converter

This block takes a raw bit pattern in a wide binary interchange floating-point format and returns the same value in a narrower interchange format. The default build converts single precision (8-bit exponent, 23-bit fraction) to half precision (5-bit exponent, 10-bit fraction). Both sets of field widths are parameters. Rounding is always round-to-nearest with ties going to the even neighbour. No other rounding mode exists and no exception flags are raised.

An upstream stage presents a source word together with a valid strobe. The conversion logic is combinational, and a single output register follows it. The result therefore appears one clock later with its own valid strobe.

The datapath sorts each input into one of four classes: in-range normal, tiny (its result is subnormal or zero), overflowing, or NaN. It uses a single unsigned comparison to separate the normal range from the rest. The normal and tiny paths share one rounder. The NaN path keeps a truncated payload.

Top module: `fp_narrow`

## Requirements
- R1: A source value whose unbiased exponent lies inside the destination's normal range converts with its exponent rebiased and its fraction rounded to nearest-even. Discarded bits above half an ulp round up. Discarded bits below half an ulp truncate. An exact half rounds up only when the kept LSB is 1. For example, 0x3F801000 gives 0x3C00, 0x3F803000 gives 0x3C02, and 0x3F801001 gives 0x3C01.
- R2: A rounding carry out of the fraction field moves into the exponent field. 0x477FF000 becomes infinity, 0x7C00. 0x387FF000 (just below the smallest normal) becomes 0x0400.
- R3: A value below the destination normal range first has its hidden one restored. It is then shifted right with a sticky bit and rounded to nearest-even into a subnormal. For example, 0x33800000 gives 0x0001, 0x33000000 (exact half) gives 0x0000, 0x33000001 gives 0x0001, and 0x33C00000 gives 0x0002.
- R4: A NaN input (all-ones exponent with a nonzero fraction) gives an all-ones destination exponent with the top fraction bit (the quiet bit) set. The lower destination fraction bits take the source fraction bits just below the source quiet bit, truncated from the bottom. For example, 0x7F800001 gives 0x7E00 and 0x7FA02000 gives 0x7F01.
- R5: Any non-NaN magnitude at or above twice the largest destination binade gives infinity (all-ones exponent, zero fraction). This includes source infinity.
- R6: A source zero, a source subnormal, or a value whose alignment shift exceeds the source fraction width gives a magnitude of exactly zero.
- R7: The destination sign bit (MSB) always equals the source sign bit (MSB), including for zeros, infinities and NaNs.
- R8: out_valid is high exactly one clock after in_valid was high. out_bits then holds the converted value of the word accepted at that edge.
- R9: While in_valid is low, out_bits keeps its previous value whatever in_bits carries.
- R10: Synchronous active-high reset drives out_valid low at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source word strobe |
| in_bits | input | SRC_EXP_W+SRC_MAN_W+1 | Source floating-point bit pattern |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_bits | output | DST_EXP_W+DST_MAN_W+1 | Destination floating-point bit pattern |

## Verification
The bench builds the converter with its default widths, single precision to half precision. A 32-bit source is small enough for hand-picked corner patterns to be exact and easy to read. Those widths bring every class boundary within reach: the ties at odd and even LSBs, the carry from the largest finite value into infinity, the carry from the largest subnormal into the smallest normal, the point where the sticky shift flushes to zero, and NaN payload truncation. A pseudo-random sweep is then compared with an integer reference model of rounding written separately in the bench.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

    // Input classification carried from the classifier to the result mux.
    typedef enum logic [1:0] {
        CLS_NORM = 2'd0,
        CLS_TINY = 2'd1,
        CLS_OVF  = 2'd2,
        CLS_NAN  = 2'd3
    } fpn_cls_e;

    // Round-to-nearest-even increment decision.
    function automatic logic rne_up(input logic lsb, input logic above, input logic tie);
        return above | (tie & lsb);
    endfunction

endpackage

// File: rtl/fpn_classify.sv
module fpn_classify
    import fpn_pkg::*;
#(
    parameter int SRC_EXP_W = 8,
    parameter int SRC_MAN_W = 23,
    parameter int DST_EXP_W = 5,
    parameter int DST_MAN_W = 10
) (
    input  logic [SRC_EXP_W+SRC_MAN_W-1:0] mag,
    output fpn_cls_e                       cls
);
    localparam int AW       = SRC_EXP_W + SRC_MAN_W;
    localparam int SRC_BIAS = (1 << (SRC_EXP_W - 1)) - 1;
    localparam int DST_BIAS = (1 << (DST_EXP_W - 1)) - 1;
    localparam int DST_TOP  = (1 << DST_EXP_W) - 1;
    localparam logic [AW-1:0] LO_EDGE = AW'(SRC_BIAS + 1 - DST_BIAS) << SRC_MAN_W;
    localparam logic [AW-1:0] HI_EDGE = AW'(SRC_BIAS + DST_TOP - DST_BIAS) << SRC_MAN_W;
    localparam logic [AW-1:0] SRC_INF = AW'((1 << SRC_EXP_W) - 1) << SRC_MAN_W;

    logic [AW-1:0] d_lo, d_hi;
    logic          in_range;

    always_comb begin
        // Wraparound: both differences sit below the span only in range.
        d_lo     = mag - LO_EDGE;
        d_hi     = mag - HI_EDGE;
        in_range = d_lo < d_hi;
        if (in_range)           cls = CLS_NORM;
        else if (mag > SRC_INF) cls = CLS_NAN;
        else if (mag >= HI_EDGE) cls = CLS_OVF;
        else                    cls = CLS_TINY;
    end
endmodule

// File: rtl/fpn_align.sv
module fpn_align
    import fpn_pkg::*;
#(
    parameter int SRC_EXP_W = 8,
    parameter int SRC_MAN_W = 23,
    parameter int DST_EXP_W = 5,
    parameter int DST_MAN_W = 10
) (
    input  logic [SRC_EXP_W+SRC_MAN_W-1:0] mag,
    input  fpn_cls_e                       cls,
    output logic [DST_EXP_W+DST_MAN_W-1:0] keep,
    output logic [SRC_MAN_W-DST_MAN_W-1:0] rbits
);
    localparam int AW       = SRC_EXP_W + SRC_MAN_W;
    localparam int KW       = DST_EXP_W + DST_MAN_W;
    localparam int SH       = SRC_MAN_W - DST_MAN_W;
    localparam int NW       = SRC_EXP_W + DST_MAN_W;
    localparam int SRC_BIAS = (1 << (SRC_EXP_W - 1)) - 1;
    localparam int DST_BIAS = (1 << (DST_EXP_W - 1)) - 1;
    localparam logic [NW-1:0] REBIAS = NW'(SRC_BIAS - DST_BIAS) << DST_MAN_W;

    logic [NW-1:0]        norm_full;
    logic [SRC_MAN_W:0]   sig, lost, denorm;
    logic [31:0]          shamt;
    logic                 sticky;

    always_comb begin
        // Normal path: drop the low fraction bits and rebias the exponent.
        norm_full = mag[AW-1:SH] - REBIAS;

        // Tiny path: restore the hidden one, shift with sticky.
        sig    = {1'b1, mag[SRC_MAN_W-1:0]};
        shamt  = 32'(SRC_BIAS - DST_BIAS + 1) - 32'(mag[AW-1:SRC_MAN_W]);
        lost   = sig & ~({(SRC_MAN_W+1){1'b1}} << shamt);
        sticky = |lost;
        denorm = (sig >> shamt) | {{SRC_MAN_W{1'b0}}, sticky};

        keep  = '0;
        rbits = '0;
        if (cls == CLS_NORM) begin
            keep  = norm_full[KW-1:0];
            rbits = mag[SH-1:0];
        end else if (cls == CLS_TINY && shamt <= 32'(SRC_MAN_W)) begin
            keep  = {{(DST_EXP_W-1){1'b0}}, denorm[SRC_MAN_W:SH]};
            rbits = denorm[SH-1:0];
        end
    end
endmodule

// File: rtl/fpn_rne.sv
module fpn_rne
    import fpn_pkg::*;
#(
    parameter int KW = 15,
    parameter int RB = 13
) (
    input  logic [KW-1:0] keep,
    input  logic [RB-1:0] rbits,
    output logic [KW-1:0] rounded
);
    localparam logic [RB-1:0] HALF = RB'(1) << (RB - 1);

    logic up;

    always_comb begin
        up      = rne_up(keep[0], rbits > HALF, rbits == HALF);
        // A carry out of the fraction ripples straight into the exponent.
        rounded = keep + {{(KW-1){1'b0}}, up};
    end
endmodule

// File: rtl/fp_narrow.sv
module fp_narrow
    import fpn_pkg::*;
#(
    parameter int SRC_EXP_W = 8,
    parameter int SRC_MAN_W = 23,
    parameter int DST_EXP_W = 5,
    parameter int DST_MAN_W = 10
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   in_valid,
    input  logic [SRC_EXP_W+SRC_MAN_W:0]           in_bits,
    output logic                                   out_valid,
    output logic [DST_EXP_W+DST_MAN_W:0]           out_bits
);
    localparam int SW = SRC_EXP_W + SRC_MAN_W + 1;
    localparam int DW = DST_EXP_W + DST_MAN_W + 1;
    localparam int KW = DW - 1;
    localparam int SH = SRC_MAN_W - DST_MAN_W;
    localparam logic [DST_EXP_W-1:0] DST_TOP = '1;

    fpn_cls_e      cls;
    logic [KW-1:0] keep, rounded, mag_res;
    logic [SH-1:0] rbits;

    fpn_classify #(
        .SRC_EXP_W(SRC_EXP_W), .SRC_MAN_W(SRC_MAN_W),
        .DST_EXP_W(DST_EXP_W), .DST_MAN_W(DST_MAN_W)
    ) cls_i (
        .mag(in_bits[SW-2:0]),
        .cls(cls)
    );

    fpn_align #(
        .SRC_EXP_W(SRC_EXP_W), .SRC_MAN_W(SRC_MAN_W),
        .DST_EXP_W(DST_EXP_W), .DST_MAN_W(DST_MAN_W)
    ) aln_i (
        .mag(in_bits[SW-2:0]),
        .cls(cls),
        .keep(keep),
        .rbits(rbits)
    );

    fpn_rne #(.KW(KW), .RB(SH)) rne_i (
        .keep(keep),
        .rbits(rbits),
        .rounded(rounded)
    );

    always_comb begin
        case (cls)
            CLS_NAN: mag_res = {DST_TOP, 1'b1, in_bits[SRC_MAN_W-2:SH]};
            CLS_OVF: mag_res = {DST_TOP, {DST_MAN_W{1'b0}}};
            default: mag_res = rounded;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_bits  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_bits <= {in_bits[SW-1], mag_res};
        end
    end
endmodule

module fp_narrow_chk #(
    parameter int SRC_EXP_W = 8,
    parameter int SRC_MAN_W = 23,
    parameter int DST_EXP_W = 5,
    parameter int DST_MAN_W = 10
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         in_valid,
    input logic [SRC_EXP_W+SRC_MAN_W:0] in_bits,
    input logic                         out_valid,
    input logic [DST_EXP_W+DST_MAN_W:0] out_bits
);
    localparam int SW = SRC_EXP_W + SRC_MAN_W + 1;
    localparam int DW = DST_EXP_W + DST_MAN_W + 1;
    localparam logic [SW-2:0] S_INF = {{SRC_EXP_W{1'b1}}, {SRC_MAN_W{1'b0}}};
    localparam logic [DW-2:0] D_INF = {{DST_EXP_W{1'b1}}, {DST_MAN_W{1'b0}}};

    a_r10_reset_clears: assert property (@(posedge clk) rst |=> !out_valid);

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_bits));

    a_r7_sign_pass: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_bits[DW-1] == $past(in_bits[SW-1]));

    a_r4_nan_quiet: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_bits[SW-2:0] > S_INF) |=>
        (&out_bits[DW-2:DST_MAN_W]) && out_bits[DST_MAN_W-1]);

    a_r5_inf_maps: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_bits[SW-2:0] == S_INF) |=> out_bits[DW-2:0] == D_INF);

    a_r6_zero_maps: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_bits[SW-2:SRC_MAN_W] == '0) |=> out_bits[DW-2:0] == '0);
endmodule

bind fp_narrow fp_narrow_chk #(
    .SRC_EXP_W(SRC_EXP_W), .SRC_MAN_W(SRC_MAN_W),
    .DST_EXP_W(DST_EXP_W), .DST_MAN_W(DST_MAN_W)
) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(in_bits),
    .out_valid(out_valid), .out_bits(out_bits)
);

// File: tb/fp_narrow_tb_top.sv
module fp_narrow_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_bits = '0;
    logic        out_valid;
    logic [15:0] out_bits;
    int          n_run = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    fp_narrow dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(in_bits),
        .out_valid(out_valid), .out_bits(out_bits)
    );

    function automatic logic [63:0] rne_div(input logic [63:0] m, input int sh);
        logic [63:0] q, rem, half;
        if (sh > 60) return 64'd0;
        q    = m >> sh;
        rem  = m & ((64'd1 << sh) - 64'd1);
        half = 64'd1 << (sh - 1);
        if (rem > half || (rem == half && q[0])) q = q + 64'd1;
        return q;
    endfunction

    function automatic logic [15:0] ref_cvt(input logic [31:0] a);
        logic        s;
        logic [63:0] m, r;
        int          ue, he;
        s = a[31];
        if (a[30:23] == 8'hFF) begin
            if (a[22:0] != 0) return {s, 5'h1F, 1'b1, a[21:13]};
            return {s, 15'h7C00};
        end
        if (a[30:23] == 8'h00) return {s, 15'h0};
        m  = {40'd0, 1'b1, a[22:0]};
        ue = int'(a[30:23]) - 127;
        if (ue > 15) return {s, 15'h7C00};
        if (ue >= -14) begin
            r  = rne_div(m, 13);
            he = ue + 15;
            if (r == 64'd2048) begin r = 64'd1024; he = he + 1; end
            if (he >= 31) return {s, 15'h7C00};
            return {s, he[4:0], r[9:0]};
        end
        r = rne_div(m, 13 + (-14 - ue));
        return {s, r[14:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic convert(input logic [31:0] a, output logic [15:0] y, output logic v);
        @(negedge clk);
        in_valid = 1'b1;
        in_bits  = a;
        @(negedge clk);
        in_valid = 1'b0;
        y = out_bits;
        v = out_valid;
    endtask

    task automatic one(input string req, input logic [31:0] a, input logic [15:0] exp);
        logic [15:0] y;
        logic        v;
        convert(a, y, v);
        chk(req, {16'd0, y}, {16'd0, exp});
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        chk("R10 out_valid in reset", {31'd0, out_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        in_valid = 1'b1;
        in_bits  = 32'h3F800000;
        rst      = 1'b1;
        @(negedge clk);
        chk("R10 reset beats in_valid", {31'd0, out_valid}, 32'd0);
        rst      = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic t_normal();
        one("R1 one", 32'h3F800000, 16'h3C00);
        one("R1 tie even lsb", 32'h3F801000, 16'h3C00);
        one("R1 tie odd lsb", 32'h3F803000, 16'h3C02);
        one("R1 above half", 32'h3F801001, 16'h3C01);
        one("R1 below half", 32'h3F800FFF, 16'h3C00);
        one("R1 largest finite", 32'h477FE000, 16'h7BFF);
        one("R1 smallest normal", 32'h38800000, 16'h0400);
    endtask

    task automatic t_carry();
        one("R2 max finite to inf", 32'h477FF000, 16'h7C00);
        one("R2 max subnormal to normal", 32'h387FF000, 16'h0400);
    endtask

    task automatic t_tiny();
        one("R3 smallest subnormal", 32'h33800000, 16'h0001);
        one("R3 exact half ulp", 32'h33000000, 16'h0000);
        one("R3 sticky above half", 32'h33000001, 16'h0001);
        one("R3 tie odd subnormal", 32'h33C00000, 16'h0002);
    endtask

    task automatic t_nan();
        one("R4 signalling nan", 32'h7F800001, 16'h7E00);
        one("R4 payload nan", 32'h7FA02000, 16'h7F01);
        one("R4 negative quiet nan", 32'hFFC04000, 16'hFE02);
    endtask

    task automatic t_ovf();
        one("R5 two to sixteen", 32'h47800000, 16'h7C00);
        one("R5 huge", 32'h7149F2CA, 16'h7C00);
        one("R5 plus inf", 32'h7F800000, 16'h7C00);
        one("R5 minus inf", 32'hFF800000, 16'hFC00);
    endtask

    task automatic t_zero();
        one("R6 plus zero", 32'h00000000, 16'h0000);
        one("R6 source subnormal", 32'h00000001, 16'h0000);
        one("R6 flush tiny", 32'h0DA24260, 16'h0000);
        one("R7 minus zero", 32'h80000000, 16'h8000);
        one("R7 minus two", 32'hC0000000, 16'hC000);
    endtask

    task automatic t_valid_hold();
        logic [15:0] y;
        logic        v;
        convert(32'h3F800000, y, v);
        chk("R8 out_valid after in_valid", {31'd0, v}, 32'd1);
        @(negedge clk);
        in_bits = 32'h40000000;
        chk("R8 out_valid drops", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        chk("R9 out_bits held while idle", {16'd0, out_bits}, 32'h3C00);
    endtask

    task automatic t_sweep();
        logic [31:0] lfsr = 32'hACE1_2468;
        logic [15:0] y;
        logic        v;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            convert(lfsr, y, v);
            chk("R1 sweep vs model", {16'd0, y}, {16'd0, ref_cvt(lfsr)});
        end
    endtask

    initial begin
        t_reset();
        t_normal();
        t_carry();
        t_tiny();
        t_nan();
        t_ovf();
        t_zero();
        t_valid_hold();
        t_sweep();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule